// File: doc/BRIEF.md
# Sixteen-to-One Serializer with Selectable Bit Order

This block turns a stream of 16-bit parallel words into one serial bit stream, one bit per rising edge of the fast serial clock. A free-running 4-bit phase counter divides the serial clock by sixteen. It marks the single cycle in which the next word is captured, and it also produces a word-rate clock. That word-rate clock drives the read side of the upstream elastic buffer and can be sent out for counter-clocked transfers.

The order of the bits within each word is chosen at run time: lowest bit first or highest bit first. An active-low enable forces the serial output to zero while the shifting carries on underneath, so the output resumes in step when the enable returns. Clock generation and output drivers belong to neighbouring blocks.

Top module: `par2ser_tx`

## Requirements
- R1: Rising edges are counted from reset release; the edge after reset release is edge 1. The word on `par_word` is captured only at edges 16, 32, 48 and so on, which are the edges that end each 16-cycle phase.
- R2: After a capture edge, `ser_data` shows the first bit of the captured word. Each of the next 15 edges moves to the following bit. The first bit of the next word comes at the very next edge, with no gap and no repeated bit.
- R3: `word_clk` is the serial clock divided by 16. After edge k it is 1 when (k mod 16) is 8 to 15 and 0 when it is 0 to 7. It therefore rises 8 cycles before each capture edge and falls at the capture edge.
- R4: With `msb_first` = 0 at the capture edge, bit 0 of the word goes out first, followed by bits 1, 2 and so on up to 15.
- R5: With `msb_first` = 1 at the capture edge, bit 15 goes out first, followed by bits 14 and so on down to 0.
- R6: Changes to `par_word` or `msb_first` between capture edges have no effect on the word being sent.
- R7: `ser_data` is 0 after any edge at which `data_en` was 0. When `data_en` is 1, the current bit passes through. The bit position keeps advancing while the output is forced to zero.
- R8: `rst_n` is an asynchronous active-low reset. While it is low, `ser_data` and `word_clk` are 0. After release, `ser_data` stays 0 until the first word is captured at edge 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock; everything updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_word | input | 16 | Parallel word from the elastic buffer read side |
| msb_first | input | 1 | Bit order: 0 sends bit 0 first, 1 sends bit 15 first |
| data_en | input | 1 | Active-low squelch: 0 forces the serial output to zero |
| ser_data | output | 1 | Serial data stream |
| word_clk | output | 1 | Serial clock divided by 16, 50% duty |

## Verification
The bench sends single-bit words in both orders, which exposes a design that reverses the order or drops an end bit. It also checks the bit sent right after each capture edge: a one-cycle error in where the word is loaded would show up there as a repeated or shifted bit. Partway through each word, the bench scrambles `par_word` and `msb_first`, so a design that keeps sampling them outside the capture edge would corrupt the later bits. A two-cycle squelch pulse inside a word tests that exactly those two bits are zeroed and the stream resumes in place rather than restarting. A reset in the middle of a word checks that both outputs clear at once and that zeros follow until the next full word.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic {
        ORDER_LSB = 1'b0,
        ORDER_MSB = 1'b1
    } bit_order_e;
endpackage

// File: rtl/ser_phase_ctr.sv
module ser_phase_ctr #(
    parameter int unsigned WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic wclk_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wclk;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        st_d.wclk = (st_d.cnt >= HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = (st_q.cnt == LAST);
    assign wclk_o = st_q.wclk;

    // R1: phase advances by one per edge and wraps after the last slot
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cnt == (($past(st_q.cnt) == LAST) ? '0 : $past(st_q.cnt) + 1'b1));
    // R2: load strobe lasts exactly one serial cycle
    assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
    // R3: divided clock is low in the cycle after a load
    assert_wclk_low_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !wclk_o);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  ser_pkg::bit_order_e order_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shift_t;

    shift_t st_d, st_q;
    logic [WORD_W-1:0] reversed;
    logic [WORD_W-1:0] ordered;

    for (genvar i = 0; i < WORD_W; i++) begin : g_rev
        assign reversed[i] = word_i[WORD_W-1-i];
    end

    assign ordered = (order_i == ser_pkg::ORDER_MSB) ? reversed : word_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            bit_o   = ordered[0];
            st_d.sr = {1'b0, ordered[WORD_W-1:1]};
        end else begin
            bit_o   = st_q.sr[0];
            st_d.sr = {1'b0, st_q.sr[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the top slot is empty once a word has been taken in
    assert_top_slot_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !st_q.sr[WORD_W-1]);
endmodule

// File: rtl/ser_out_stage.sv
module ser_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic en_i,
    output logic ser_o
);
    typedef struct packed {
        logic dout;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.dout = en_i & bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o = st_q.dout;
endmodule

// File: rtl/par2ser_tx.sv
module par2ser_tx #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] par_word,
    input  logic              msb_first,
    input  logic              data_en,
    output logic              ser_data,
    output logic              word_clk
);
    logic load;
    logic next_bit;
    ser_pkg::bit_order_e order;

    assign order = msb_first ? ser_pkg::ORDER_MSB : ser_pkg::ORDER_LSB;

    ser_phase_ctr #(.WORD_W(WORD_W)) u_phase (
        .clk    (ser_clk),
        .rst_n  (rst_n),
        .load_o (load),
        .wclk_o (word_clk)
    );

    ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (ser_clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (par_word),
        .order_i (order),
        .bit_o   (next_bit)
    );

    ser_out_stage u_out (
        .clk   (ser_clk),
        .rst_n (rst_n),
        .bit_i (next_bit),
        .en_i  (data_en),
        .ser_o (ser_data)
    );

    // R7: squelch forces the serial line low on the following cycle
    assert_squelch_zero_R7: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !data_en |=> !ser_data);
    // R3: word clock only rises while the load strobe is idle
    assert_wclk_rise_mid_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
        $rose(word_clk) |-> !load);
endmodule

// File: tb/tb_par2ser_tx.sv
`timescale 1ns/1ps
module tb_par2ser_tx;
    logic        ser_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] par_word = 16'h0;
    logic        msb_first = 1'b0;
    logic        data_en = 1'b1;
    logic        ser_data;
    logic        word_clk;

    int checks = 0;
    int fails  = 0;

    // {data_en, msb_first, word}
    localparam logic [17:0] VEC [0:6] = '{
        {1'b1, 1'b0, 16'h0001},
        {1'b1, 1'b1, 16'h0001},
        {1'b1, 1'b0, 16'hA5C3},
        {1'b1, 1'b1, 16'hA5C3},
        {1'b0, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 16'h8000},
        {1'b1, 1'b0, 16'h3C96}
    };

    par2ser_tx dut (
        .ser_clk   (ser_clk),
        .rst_n     (rst_n),
        .par_word  (par_word),
        .msb_first (msb_first),
        .data_en   (data_en),
        .ser_data  (ser_data),
        .word_clk  (word_clk)
    );

    always #2.5 ser_clk = ~ser_clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge ser_clk);
        @(negedge ser_clk);
    endtask

    task automatic apply(input logic [17:0] v);
        {data_en, msb_first, par_word} = v;
    endtask

    task automatic run_word(input logic [15:0] w, input logic o, input logic q,
                            input logic pulse, input logic [17:0] nxt);
        for (int j = 0; j < 16; j++) begin
            logic qe, eb;
            string tag;
            step();
            qe = (pulse && (j == 5 || j == 6)) ? 1'b0 : q;
            eb = o ? w[15-j] : w[j];
            if (j == 0)      tag = "R1 R2 load point";
            else if (!qe)    tag = "R7 squelch";
            else if (j > 5)  tag = "R6 held word";
            else if (o)      tag = "R5 msb order";
            else             tag = "R4 lsb order";
            check(tag, ser_data, eb & qe);
            check("R3 word clock", word_clk, (j >= 8));
            if (pulse && j == 4) data_en = 1'b0;
            if (pulse && j == 6) data_en = q;
            if (j == 5) begin
                par_word  = ~w;
                msb_first = ~o;
            end
            if (j == 15) apply(nxt);
        end
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        apply(VEC[0]);
        repeat (3) @(negedge ser_clk);
        check("R8 reset data", ser_data, 1'b0);
        check("R8 reset word clock", word_clk, 1'b0);
        rst_n = 1'b1;
        for (int k = 1; k < 16; k++) begin
            step();
            check("R8 zeros before first load", ser_data, 1'b0);
            check("R3 word clock", word_clk, (k >= 8));
        end
        for (int v = 0; v < 7; v++) begin
            run_word(VEC[v][15:0], VEC[v][16], VEC[v][17], 1'b0,
                     (v < 6) ? VEC[v+1] : {1'b1, 1'b0, 16'hFFFF});
        end
        // R7 squelch pulse inside a word; shifting continues underneath
        run_word(16'hFFFF, 1'b0, 1'b1, 1'b1, {1'b1, 1'b1, 16'hFFFF});
        // R8 reset in the middle of a word
        for (int k = 0; k < 10; k++) step();
        check("R5 before mid reset", ser_data, 1'b1);
        check("R3 before mid reset", word_clk, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R8 async clear data", ser_data, 1'b0);
        check("R8 async clear word clock", word_clk, 1'b0);
        @(negedge ser_clk);
        rst_n = 1'b1;
        for (int k = 1; k < 16; k++) begin
            step();
            check("R8 zeros after mid reset", ser_data, 1'b0);
        end
        step();
        check("R1 first load after mid reset", ser_data, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule